// File: doc/BRIEF.md
# Fault-Remapping Cache Line Decoder

This block is the line-select decoder of a cache whose lines may be known to be defective. With no faults marked, it turns the line-index field of a lookup into a one-hot select. Each node of the binary decode tree has a fault bit held in flip-flops. When the node an index would enter is marked faulty, the decode is steered into that node's sibling. At the leaf level a bad line folds onto its buddy line. Higher up, a bad pair folds onto the neighbouring pair, a bad quad onto the other quad, and so on. A steered address stays cacheable. It only shares the line it lands on with the addresses that already map there.

A node counts as faulty when its own bit is set, or when both of its children count as faulty. The decode walks from the root toward the leaves. At each level it takes the child named by the index bit for that level, unless that child is faulty, in which case it takes the sibling. If both halves under the root are faulty, no line is selected and an all-faulty flag tells the cache to treat the access as an uncached miss. The fault bits are loaded at boot through a small write port. Writes are only accepted while no lookup is being made.

Fault bits are addressed as one flat space. Leaf (line) bits come first at addresses 0 to N_LINES-1, then the pair nodes, then each higher level in turn. A node j at level k (leaves are level 0) sits at address 2*N_LINES - 2*(N_LINES>>k) + j. Node j at level k covers lines j*2^k to (j+1)*2^k - 1. There are 2*N_LINES-2 bits in total, and the root has none.

Top module: `fault_remap_decoder`

## Requirements
- R1: With every fault bit clear, a lookup asserts only line_sel_o bit number index_i, with remapped_o and all_faulty_o low.
- R2: While lookup_i is low, line_sel_o is all zero and remapped_o and all_faulty_o are low, whatever the index and fault bits.
- R3: If line i's leaf bit (address i) is set and its buddy line i^1 and their ancestors are healthy, index i selects line i^1 with remapped_o high. Index i^1 still selects line i^1 with remapped_o low. This holds both ways, so a bad odd line folds onto the even one.
- R4: If the pair bit at address N_LINES+j is set, indexes in lines 2j and 2j+1 are steered into pair j^1. There index bit 0 picks the line, subject to that pair's own leaf faults.
- R5: A node also counts as faulty when both of its children count as faulty, and this applies at every level of the tree. For example, with 8 lines, if leaf bits 4 and 5 are set, index 4 selects line 6. If the level-2 bit at address 12 is set, index 1 selects line 5.
- R6: When both halves under the root count as faulty, a lookup asserts no line select, raises all_faulty_o, and keeps remapped_o low.
- R7: During a lookup that is not all-faulty, remapped_o is high exactly when the selected line differs from index_i.
- R8: After reset all fault bits are clear, so every index decodes plainly.
- R9: A write of cfg_fault_i to address cfg_addr_i with cfg_we_i high and lookup_i low takes effect on lookups from the next clock edge. A write made while lookup_i is high is ignored. Addresses of 2*N_LINES-2 and above are ignored. Writing 0 restores a node to healthy.
- R10: A lookup never asserts more than one select bit, and never selects a line whose own leaf fault bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with clk_i |
| lookup_i | input | 1 | Lookup strobe; the outputs are valid in the same cycle |
| index_i | input | $clog2(N_LINES) | Line-index field of the access |
| cfg_we_i | input | 1 | Fault-bit write enable |
| cfg_addr_i | input | $clog2(2*N_LINES-2) | Fault-bit address in the flat node space |
| cfg_fault_i | input | 1 | Value written: 1 marks the node faulty |
| line_sel_o | output | N_LINES | One-hot line select |
| remapped_o | output | 1 | Selected line differs from the plain decode |
| all_faulty_o | output | 1 | No healthy line can be reached; treat as uncached miss |

## Verification
The bench builds the decoder with N_LINES = 8, which gives three decode levels and 14 fault bits. That size reaches leaf folding, pair-to-pair steering, and the level that swaps a whole half of the lines. It also covers derived faults from two bad children and the all-faulty case, none of which a four-line tree can show for the top level. Random fault densities, from sparse to dense, combine faults at several levels. The invalid addresses 14 and 15 exist in the 4-bit address space, so the ignored-address rule is exercised as well.

// File: rtl/frd_pkg.sv
package frd_pkg;

  // Flat address of the first fault bit at a given tree level (leaves = 0).
  function automatic int node_base(input int n_lines, input int level);
    return 2 * n_lines - 2 * (n_lines >> level);
  endfunction

  // Number of fault bits in the whole tree (every node but the root).
  function automatic int node_count(input int n_lines);
    return 2 * n_lines - 2;
  endfunction

endpackage

// File: rtl/frd_fault_regs.sv
module frd_fault_regs #(
  parameter int N_NODES = 14,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic               wr_data_i,
  output logic [N_NODES-1:0] fault_o
);

  logic [N_NODES-1:0] fault_d;
  logic [N_NODES-1:0] fault_q;
  logic               addr_ok;
  logic               upd_en;

  assign addr_ok = (wr_addr_i < ADDR_W'(N_NODES));
  assign upd_en  = wr_en_i & addr_ok;

  // next-state
  always_comb begin
    fault_d = fault_q;
    if (upd_en) begin
      fault_d[wr_addr_i] = wr_data_i;
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= '0;
    end else if (upd_en) begin
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/frd_health.sv
module frd_health #(
  parameter int N_LINES = 8,
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int N_NODES = frd_pkg::node_count(N_LINES)
) (
  input  logic [N_NODES-1:0] raw_i,
  output logic [N_NODES-1:0] eff_o
);

  // A node is unusable if it is marked, or if both of its children are unusable.
  for (genvar lv = 0; lv < IDX_W; lv++) begin : lvl_g
    localparam int BASE = frd_pkg::node_base(N_LINES, lv);
    localparam int CNT  = N_LINES >> lv;
    localparam int PBAS = (lv == 0) ? 0 : frd_pkg::node_base(N_LINES, lv - 1);
    logic [CNT-1:0] v;
    if (lv == 0) begin : g_leaf
      assign v = raw_i[CNT-1:0];
    end else begin : g_inner
      for (genvar j = 0; j < CNT; j++) begin : node_g
        assign v[j] = raw_i[BASE + j] | (lvl_g[lv-1].v[2*j] & lvl_g[lv-1].v[2*j+1]);
      end
    end
    assign eff_o[BASE +: CNT] = v;
  end

endmodule

// File: rtl/frd_steer.sv
module frd_steer #(
  parameter int N_LINES = 8,
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int N_NODES = frd_pkg::node_count(N_LINES)
) (
  input  logic [N_NODES-1:0] eff_i,
  input  logic [IDX_W-1:0]   index_i,
  input  logic               enable_i,
  output logic [N_LINES-1:0] sel_o,
  output logic               remapped_o,
  output logic               all_faulty_o
);

  logic [IDX_W-1:0] dead_vec;
  logic [IDX_W-1:0] line_idx;
  logic             all_f;
  logic             live;

  // One steering stage per tree level; the top stage starts from an empty prefix.
  for (genvar lv = 0; lv < IDX_W; lv++) begin : stg_g
    localparam int BASE = frd_pkg::node_base(N_LINES, lv);
    localparam int CNT  = N_LINES >> lv;
    logic [N_LINES-1:0] lvl_eff;
    logic [IDX_W-1:0]   prefix;
    logic [IDX_W-1:0]   cand;
    logic [IDX_W-1:0]   pick;
    logic               blocked;

    if (CNT == N_LINES) begin : g_full
      assign lvl_eff = eff_i[BASE +: CNT];
    end else begin : g_pad
      assign lvl_eff = {{(N_LINES-CNT){1'b0}}, eff_i[BASE +: CNT]};
    end

    if (lv == IDX_W - 1) begin : g_root
      assign prefix = '0;
    end else begin : g_below
      assign prefix = stg_g[lv+1].pick;
    end

    assign cand    = (prefix << 1) | {{(IDX_W-1){1'b0}}, index_i[lv]};
    assign blocked = lvl_eff[cand] & lvl_eff[cand ^ {{(IDX_W-1){1'b0}}, 1'b1}];
    assign pick    = lvl_eff[cand] ? (cand ^ {{(IDX_W-1){1'b0}}, 1'b1}) : cand;
    assign dead_vec[lv] = blocked;
  end

  assign line_idx = stg_g[0].pick;
  assign all_f    = |dead_vec;
  assign live     = enable_i & ~all_f;

  for (genvar j = 0; j < N_LINES; j++) begin : sel_g
    assign sel_o[j] = live & (line_idx == IDX_W'(j));
  end

  assign remapped_o   = live & (line_idx != index_i);
  assign all_faulty_o = enable_i & all_f;

endmodule

// File: rtl/fault_remap_decoder.sv
module fault_remap_decoder #(
  parameter int N_LINES = 8,
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int N_NODES = frd_pkg::node_count(N_LINES),
  localparam int ADDR_W  = $clog2(N_NODES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_i,
  input  logic [IDX_W-1:0]   index_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic               cfg_fault_i,
  output logic [N_LINES-1:0] line_sel_o,
  output logic               remapped_o,
  output logic               all_faulty_o
);

  logic [N_NODES-1:0] fault_q;
  logic [N_NODES-1:0] eff_fault;
  logic               wr_ok;

  // Fault bits may only change while no lookup is using them.
  assign wr_ok = cfg_we_i & ~lookup_i;

  frd_fault_regs #(
    .N_NODES (N_NODES),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (cfg_fault_i),
    .fault_o   (fault_q)
  );

  frd_health #(
    .N_LINES (N_LINES)
  ) u_health (
    .raw_i (fault_q),
    .eff_o (eff_fault)
  );

  frd_steer #(
    .N_LINES (N_LINES)
  ) u_steer (
    .eff_i        (eff_fault),
    .index_i      (index_i),
    .enable_i     (lookup_i),
    .sel_o        (line_sel_o),
    .remapped_o   (remapped_o),
    .all_faulty_o (all_faulty_o)
  );

endmodule

// File: rtl/frd_checker.sv
module frd_checker #(
  parameter int N_LINES = 8,
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int N_NODES = 2 * N_LINES - 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lookup_i,
  input logic [IDX_W-1:0]   index_i,
  input logic [N_LINES-1:0] line_sel_o,
  input logic               remapped_o,
  input logic               all_faulty_o,
  input logic [N_NODES-1:0] fault_q
);

  logic [N_LINES-1:0] plain_sel;
  assign plain_sel = {{(N_LINES-1){1'b0}}, 1'b1} << index_i;

  p_plain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && fault_q == '0) |-> (line_sel_o == plain_sel && !remapped_o && !all_faulty_o));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |-> (line_sel_o == '0 && !remapped_o && !all_faulty_o));

  p_dead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_faulty_o |-> (line_sel_o == '0 && !remapped_o));

  p_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !all_faulty_o) |-> ($countones(line_sel_o) == 1));

  p_remap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !all_faulty_o) |-> (remapped_o == (line_sel_o != plain_sel)));

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> $stable(fault_q));

  p_no_bad_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |-> ($onehot0(line_sel_o) && (line_sel_o & fault_q[N_LINES-1:0]) == '0));

endmodule

bind fault_remap_decoder frd_checker #(
  .N_LINES (N_LINES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_i     (lookup_i),
  .index_i      (index_i),
  .line_sel_o   (line_sel_o),
  .remapped_o   (remapped_o),
  .all_faulty_o (all_faulty_o),
  .fault_q      (fault_q)
);

// File: tb/fault_remap_decoder_tb.sv
`timescale 1ns/1ps
module fault_remap_decoder_tb;

  localparam int N  = 8;
  localparam int IW = 3;
  localparam int NN = 14;
  localparam int AW = 4;

  logic          clk;
  logic          rst_ni;
  logic          lookup;
  logic [IW-1:0] index;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic          cfg_fault;
  logic [N-1:0]  line_sel;
  logic          remapped;
  logic          all_faulty;

  int  n_tests;
  int  n_fail;
  bit  done;
  logic [NN-1:0] shadow;

  fault_remap_decoder #(.N_LINES(N)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .lookup_i     (lookup),
    .index_i      (index),
    .cfg_we_i     (cfg_we),
    .cfg_addr_i   (cfg_addr),
    .cfg_fault_i  (cfg_fault),
    .line_sel_o   (line_sel),
    .remapped_o   (remapped),
    .all_faulty_o (all_faulty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected line from the requirements: -1 means nothing reachable.
  function automatic int model_line(input int idx);
    bit em [NN];
    int prefix;
    int cand;
    for (int j = 0; j < N; j++) em[j] = shadow[j];
    for (int lv = 1; lv < IW; lv++) begin
      int b  = 2 * N - 2 * (N >> lv);
      int pb = 2 * N - 2 * (N >> (lv - 1));
      for (int j = 0; j < (N >> lv); j++)
        em[b + j] = shadow[b + j] | (em[pb + 2 * j] & em[pb + 2 * j + 1]);
    end
    prefix = 0;
    for (int lv = IW - 1; lv >= 0; lv--) begin
      int b = 2 * N - 2 * (N >> lv);
      cand = prefix * 2 + ((idx >> lv) & 1);
      if (em[b + cand]) begin
        cand = cand ^ 1;
        if (em[b + cand]) return -1;
      end
      prefix = cand;
    end
    return prefix;
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp_sel,
                       input logic exp_rem, input logic exp_af);
    n_tests++;
    if (line_sel !== exp_sel || remapped !== exp_rem || all_faulty !== exp_af) begin
      n_fail++;
      $display("FAIL %s: idx=%0d sel=%b rem=%b af=%b expected sel=%b rem=%b af=%b",
               req, index, line_sel, remapped, all_faulty, exp_sel, exp_rem, exp_af);
    end
  endtask

  task automatic wr(input int addr, input logic val);
    @(negedge clk);
    lookup    = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = AW'(addr);
    cfg_fault = val;
    @(negedge clk);
    cfg_we    = 1'b0;
    if (addr < NN) shadow[addr] = val;
  endtask

  task automatic clear_all();
    for (int a = 0; a < NN; a++) wr(a, 1'b0);
  endtask

  task automatic look(input int idx, input string req);
    int e;
    logic [N-1:0] es;
    @(negedge clk);
    lookup = 1'b1;
    index  = IW'(idx);
    #1;
    e  = model_line(idx);
    es = (e < 0) ? '0 : (N'(1) << e);
    check(req, es, (e >= 0) && (e != idx), e < 0);
    lookup = 1'b0;
  endtask

  task automatic look_exp(input int idx, input int exp_line, input string req);
    logic [N-1:0] es;
    @(negedge clk);
    lookup = 1'b1;
    index  = IW'(idx);
    #1;
    es = (exp_line < 0) ? '0 : (N'(1) << exp_line);
    check(req, es, (exp_line >= 0) && (exp_line != idx), exp_line < 0);
    lookup = 1'b0;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    n_tests = 0; n_fail = 0; done = 1'b0;
    shadow = '0;
    rst_ni = 1'b0; lookup = 1'b0; index = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_fault = 1'b0;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R8 / R1: reset leaves every line healthy
    for (int i = 0; i < N; i++) look_exp(i, i, "R8 reset plain decode");
    for (int i = 0; i < N; i++) look_exp(i, i, "R1 plain decode");

    // R3: leaf fold onto buddy, both directions
    wr(0, 1'b1);
    look_exp(0, 1, "R3 line0 folds to 1");
    look_exp(1, 1, "R3 buddy unchanged");
    look_exp(2, 2, "R3 other pair untouched");
    wr(0, 1'b0); wr(1, 1'b1);
    look_exp(1, 0, "R3 line1 folds to 0");
    look_exp(0, 0, "R3 line0 plain");
    wr(1, 1'b0); wr(3, 1'b1);
    look_exp(3, 2, "R3 line3 folds to 2");
    wr(3, 1'b0);

    // R2: no lookup, nothing driven, even with faults set
    wr(5, 1'b1);
    @(negedge clk); lookup = 1'b0; index = 3'd5; #1;
    check("R2 idle outputs", '0, 1'b0, 1'b0);
    wr(5, 1'b0);

    // R4: pair bit steers to neighbour pair, leaf faults still apply there
    wr(8, 1'b1);
    look_exp(0, 2, "R4 pair0 idx0 to line2");
    look_exp(1, 3, "R4 pair0 idx1 to line3");
    wr(2, 1'b1);
    look_exp(0, 3, "R4 pair0 idx0 to line3 with leaf2 bad");
    look_exp(2, 3, "R4 idx2 folds in its own pair");
    clear_all();

    // R5: derived pair fault and level-2 steering
    wr(4, 1'b1); wr(5, 1'b1);
    look_exp(4, 6, "R5 derived pair fault idx4");
    look_exp(5, 7, "R5 derived pair fault idx5");
    clear_all();
    wr(12, 1'b1);
    look_exp(1, 5, "R5 half fault idx1 to line5");
    look_exp(6, 6, "R5 other half plain");
    clear_all();

    // R6: everything faulty
    for (int a = 0; a < N; a++) wr(a, 1'b1);
    look_exp(3, -1, "R6 all leaves faulty");
    clear_all();
    wr(12, 1'b1); wr(13, 1'b1);
    look_exp(6, -1, "R6 both halves marked");
    clear_all();

    // R9: write during lookup ignored
    @(negedge clk);
    lookup = 1'b1; index = 3'd3;
    cfg_we = 1'b1; cfg_addr = 4'd3; cfg_fault = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R9 write during lookup ignored", 8'b0000_1000, 1'b0, 1'b0);
    lookup = 1'b0;
    // R9: out-of-range addresses ignored
    wr(14, 1'b1); wr(15, 1'b1);
    for (int i = 0; i < N; i++) look_exp(i, i, "R9 invalid address ignored");
    // R9: clearing restores
    wr(6, 1'b1);
    look_exp(6, 7, "R9 write takes effect");
    wr(6, 1'b0);
    look_exp(6, 6, "R9 clear restores");

    // Random patterns with R7 and R10 checked through the model
    for (int p = 0; p < 60; p++) begin
      int dens = $urandom % 5;
      for (int a = 0; a < NN; a++) wr(a, (($urandom % 8) < dens) ? 1'b1 : 1'b0);
      if ($urandom % 4 == 0) wr(14 + ($urandom % 2), 1'b1);
      for (int i = 0; i < N; i++) look(i, "R7 R10 random pattern");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule